// File: doc/BRIEF.md
# Cache Management and Prefetch Decoder

This block is a purely combinational decode slice for the front of an instruction pipeline. It inspects one 32-bit instruction word and recognises two families: the cache-block operations (invalidate, clean, flush, zero) carried in the memory-ordering major opcode, and the three prefetch hints (instruction, read, write) that are carried inside an OR-immediate with a zero destination register.

For every word it presents exactly one verdict. The verdict is either a one-hot operation code, a request for an illegal-instruction trap on a reserved encoding, or a signal that the word belongs to some other decoder. Alongside the verdict it always forwards the base register index. For prefetches it also forwards the byte offset, already scaled and sign-extended to the machine width. Register reads, address generation, permission gating and execution belong to later stages.

Top module: `cmo_prefetch_decoder`

## Requirements
- R1: With opcode bits 6:0 = 0001111, funct3 (bits 14:12) = 010 and bits 11:7 = 00000, bits 31:20 equal to 0, 1, 2 or 4 drive op_o to 0000001 (invalidate), 0000010 (clean), 0000100 (flush) or 0001000 (zero) respectively, with illegal_o and not_mine_o low.
- R2: With opcode 0001111, funct3 010 and bits 11:7 = 00000, any other value of bits 31:20 sets illegal_o and leaves op_o at zero.
- R3: With opcode 0001111 and funct3 010 but bits 11:7 nonzero, illegal_o is set and op_o is zero, whatever bits 31:20 hold.
- R4: With opcode 0010011, funct3 110 and bits 11:7 = 00000, bits 24:20 equal to 0, 1 or 3 drive op_o to 0010000 (instruction prefetch), 0100000 (read prefetch) or 1000000 (write prefetch), with illegal_o and not_mine_o low.
- R5: With opcode 0010011, funct3 110 and bits 11:7 = 00000, any other value of bits 24:20 is an ordinary OR-immediate: not_mine_o is set, op_o is zero and illegal_o is low.
- R6: On a recognised prefetch, pf_offset_o equals bits 31:25 placed at offset bits 11:5 with bits 4:0 zero, sign-extended from bit 11 to XLEN bits; for every other word pf_offset_o is zero.
- R7: rs1_o always equals instruction bits 19:15.
- R8: For every word exactly one of these holds: op_o nonzero, illegal_o high, not_mine_o high; any word outside the two encodings above (other opcodes, other funct3 values) sets not_mine_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn_i | input | 32 | Instruction word to decode |
| op_o | output | 7 | One-hot operation: bits 0..3 invalidate, clean, flush, zero; bits 4..6 prefetch instruction, read, write |
| rs1_o | output | 5 | Base register index, instruction bits 19:15 |
| pf_offset_o | output | XLEN | Scaled, sign-extended prefetch offset; zero unless a prefetch is decoded |
| illegal_o | output | 1 | Reserved cache-block encoding; the pipeline must raise an illegal-instruction trap |
| not_mine_o | output | 1 | Word is not handled by this decoder |

## Verification
The hardest cases sit at the edges of the two encodings. One is a reserved immediate that differs from a legal one by a single bit, such as 3, 5, 8 or 0x800, under the cache-block funct3. The other is an OR-immediate with a zero destination whose kind field is 2 or another near value, which must fall through as an ordinary instruction. Uniform random words almost never land there. The stimulus therefore builds most words from a biased template. The opcode is drawn from the two families, funct3 and the destination are usually pinned to the matching values, and the immediate or kind is usually a small number. Directed words cover every legal code, the sign boundary of the offset and a nonzero destination.

// File: rtl/cmo_prefetch_decoder.sv
module cmo_prefetch_decoder #(
  parameter int XLEN = 64
) (
  input  logic [31:0]     insn_i,
  output logic [6:0]      op_o,
  output logic [4:0]      rs1_o,
  output logic [XLEN-1:0] pf_offset_o,
  output logic            illegal_o,
  output logic            not_mine_o
);

  localparam logic [6:0] OPC_MISC_MEM = 7'b0001111;
  localparam logic [6:0] OPC_OP_IMM   = 7'b0010011;
  localparam logic [2:0] F3_CBO       = 3'b010;
  localparam logic [2:0] F3_ORI       = 3'b110;
  localparam int         OFS_W        = 12;

  logic [6:0]  opcode;
  logic [2:0]  funct3;
  logic [4:0]  rd;
  logic [11:0] imm12;
  logic [4:0]  kind;
  logic        cbo_space, pf_space, cbo_hit, pf_hit;
  logic [3:0]  cbo_sel;
  logic [2:0]  pf_sel;

  assign opcode = insn_i[6:0];
  assign rd     = insn_i[11:7];
  assign funct3 = insn_i[14:12];
  assign imm12  = insn_i[31:20];
  assign kind   = insn_i[24:20];
  assign rs1_o  = insn_i[19:15];

  always_comb begin
    case (imm12)
      12'd0:   cbo_sel = 4'b0001;
      12'd1:   cbo_sel = 4'b0010;
      12'd2:   cbo_sel = 4'b0100;
      12'd4:   cbo_sel = 4'b1000;
      default: cbo_sel = 4'b0000;
    endcase
  end

  always_comb begin
    case (kind)
      5'd0:    pf_sel = 3'b001;
      5'd1:    pf_sel = 3'b010;
      5'd3:    pf_sel = 3'b100;
      default: pf_sel = 3'b000;
    endcase
  end

  assign cbo_space = (opcode == OPC_MISC_MEM) && (funct3 == F3_CBO);
  assign pf_space  = (opcode == OPC_OP_IMM) && (funct3 == F3_ORI) && (rd == 5'd0);
  assign cbo_hit   = cbo_space && (rd == 5'd0) && (cbo_sel != 4'b0000);
  assign pf_hit    = pf_space && (pf_sel != 3'b000);

  assign op_o       = {pf_hit ? pf_sel : 3'b000, cbo_hit ? cbo_sel : 4'b0000};
  assign illegal_o  = cbo_space && !cbo_hit;
  assign not_mine_o = !cbo_space && !pf_hit;

  assign pf_offset_o = pf_hit
    ? {{(XLEN-OFS_W){insn_i[31]}}, insn_i[31:25], 5'b00000}
    : '0;

  always_comb begin
    AST_OP_ONEHOT: assert ($onehot0(op_o)) else $error("op_o not one-hot");                                   // R1
    AST_RESERVED_NO_OP: assert (!(illegal_o && (op_o != 7'd0))) else $error("reserved word with an op");    // R2
    AST_OFFSET_ALIGNED: assert (pf_offset_o[4:0] == 5'd0) else $error("offset low bits set");               // R6
    AST_OFFSET_ONLY_PF: assert ((op_o[6:4] != 3'd0) || (pf_offset_o == '0)) else $error("stray offset");    // R6
    AST_OFFSET_SIGN: assert ((pf_offset_o[XLEN-1:OFS_W-1] == '0) || (&pf_offset_o[XLEN-1:OFS_W-1]))
      else $error("offset not sign-extended");                                                               // R6
    AST_ONE_VERDICT: assert ($onehot({not_mine_o, illegal_o, op_o != 7'd0})) else $error("verdict clash");  // R8
  end

endmodule

// File: tb/cmo_prefetch_decoder_tb.sv
module cmo_prefetch_decoder_tb;
  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [31:0]     insn;
  logic [6:0]      op;
  logic [4:0]      rs1;
  logic [XLEN-1:0] ofs;
  logic            illegal, not_mine;
  int              checks = 0;
  int              errors = 0;
  bit              done = 1'b0;

  always #5 clk = ~clk;

  cmo_prefetch_decoder #(.XLEN(XLEN)) u_dut (
    .insn_i(insn), .op_o(op), .rs1_o(rs1), .pf_offset_o(ofs),
    .illegal_o(illegal), .not_mine_o(not_mine)
  );

  typedef struct packed {
    logic [6:0]      op;
    logic            ill;
    logic            nm;
    logic [XLEN-1:0] ofs;
  } exp_t;

  function automatic exp_t model(input logic [31:0] w, output string req);
    exp_t e;
    logic [11:0] imm;
    e = '0;
    imm = w[31:20];
    req = "R8";
    if (w[6:0] == 7'h0F && w[14:12] == 3'd2) begin
      if (w[11:7] != 5'd0) begin e.ill = 1'b1; req = "R3"; end
      else if (imm == 12'd0) begin e.op = 7'h01; req = "R1"; end
      else if (imm == 12'd1) begin e.op = 7'h02; req = "R1"; end
      else if (imm == 12'd2) begin e.op = 7'h04; req = "R1"; end
      else if (imm == 12'd4) begin e.op = 7'h08; req = "R1"; end
      else begin e.ill = 1'b1; req = "R2"; end
    end else if (w[6:0] == 7'h13 && w[14:12] == 3'd6 && w[11:7] == 5'd0) begin
      if (w[24:20] == 5'd0 || w[24:20] == 5'd1 || w[24:20] == 5'd3) begin
        e.op = (w[24:20] == 5'd0) ? 7'h10 : (w[24:20] == 5'd1) ? 7'h20 : 7'h40;
        e.ofs = XLEN'($signed({w[31:25], 5'b0}));
        req = "R4";
      end else begin e.nm = 1'b1; req = "R5"; end
    end else e.nm = 1'b1;
    return e;
  endfunction

  task automatic check_word(input logic [31:0] w);
    exp_t  e;
    string req;
    e = model(w, req);
    @(posedge clk);
    insn = w;
    @(negedge clk);
    checks++;
    if (op !== e.op || illegal !== e.ill || not_mine !== e.nm) begin
      errors++;
      $display("FAIL %s insn=%h verdict op=%b ill=%b nm=%b expected op=%b ill=%b nm=%b",
               req, w, op, illegal, not_mine, e.op, e.ill, e.nm);
    end
    checks++;
    if (ofs !== e.ofs) begin
      errors++;
      $display("FAIL R6 insn=%h offset=%h expected %h", w, ofs, e.ofs);
    end
    checks++;
    if (rs1 !== w[19:15]) begin
      errors++;
      $display("FAIL R7 insn=%h rs1=%0d expected %0d", w, rs1, w[19:15]);
    end
  endtask

  function automatic logic [31:0] biased_word();
    logic [31:0] w;
    int          pick;
    w = $urandom;
    pick = $urandom_range(0, 9);
    if (pick < 4) begin
      w[6:0] = 7'h0F;
      if ($urandom_range(0, 7) != 0) w[14:12] = 3'd2;
      if ($urandom_range(0, 5) != 0) w[11:7] = 5'd0;
      if ($urandom_range(0, 3) != 0) w[31:20] = 12'($urandom_range(0, 9));
      else if ($urandom_range(0, 1) != 0) w[31:20] = 12'd1 << $urandom_range(0, 11);
    end else if (pick < 8) begin
      w[6:0] = 7'h13;
      if ($urandom_range(0, 7) != 0) w[14:12] = 3'd6;
      if ($urandom_range(0, 5) != 0) w[11:7] = 5'd0;
      if ($urandom_range(0, 2) != 0) w[24:20] = 5'($urandom_range(0, 5));
    end
    return w;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    insn = 32'h0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // idle word: R8 not-mine
    check_word(32'h0000_0000);
    // R1 each legal cache-block code, rs1 = 10
    check_word({12'd0, 5'd10, 3'd2, 5'd0, 7'h0F});
    check_word({12'd1, 5'd10, 3'd2, 5'd0, 7'h0F});
    check_word({12'd2, 5'd10, 3'd2, 5'd0, 7'h0F});
    check_word({12'd4, 5'd10, 3'd2, 5'd0, 7'h0F});
    // R2 reserved neighbours
    check_word({12'd3, 5'd1, 3'd2, 5'd0, 7'h0F});
    check_word({12'd5, 5'd1, 3'd2, 5'd0, 7'h0F});
    check_word({12'h800, 5'd1, 3'd2, 5'd0, 7'h0F});
    // R3 nonzero destination
    check_word({12'd0, 5'd2, 3'd2, 5'd7, 7'h0F});
    // R4 prefetch kinds with positive and negative offsets (R6)
    check_word({7'h3F, 5'd0, 5'd4, 3'd6, 5'd0, 7'h13});
    check_word({7'h40, 5'd1, 5'd4, 3'd6, 5'd0, 7'h13});
    check_word({7'h7F, 5'd3, 5'd4, 3'd6, 5'd0, 7'h13});
    // R5 ordinary ORI to x0
    check_word({7'h7F, 5'd2, 5'd4, 3'd6, 5'd0, 7'h13});
    check_word({7'h01, 5'd31, 5'd4, 3'd6, 5'd0, 7'h13});
    // R8 ORI with nonzero rd, fence funct3
    check_word({7'h00, 5'd1, 5'd4, 3'd6, 5'd3, 7'h13});
    check_word({12'd0, 5'd0, 3'd0, 5'd0, 7'h0F});
    void'($urandom(32'd20240611));
    for (int i = 0; i < 3000; i++) check_word(biased_word());
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule